// File: doc/BRIEF.md
# Grouped Interrupt Request Register Bank

This block keeps the per-group interrupt state of a grouped interrupt controller: a 4-bit request field, a 4-bit enable field, a 3-bit priority level and a 2-bit trigger mode for each of 31 groups. Groups 0 and 1 are non-maskable and groups 2 to 30 are maskable. A 124-bit raw interrupt vector feeds the groups, four inputs per group. The inputs are registered once, and a change between the live input and its registered copy counts as an edge event.

Software reaches the state through a byte-wide bus with two regions. The control region holds four bytes per group. The trigger region holds two bytes that set the trigger modes of groups 23 to 30. Downstream logic sees the masked pending bits and the level of every group, and it gets a one-cycle pulse when a non-maskable group takes an event while it has an enabled request. Priority selection and acknowledge handling are outside this block.

Top module: `irq_group_bank`

## Requirements
- R1: Raw input index n drives bit n%4 of the request field of group n/4.
- R2: In the control region, group = offset/4 and byte = offset%4. Offsets at or above 124, and bytes that a group does not decode, read 0 and ignore writes. This covers maskable bytes 2 and 3 and non-maskable bytes 1 and 2.
- R3: A read of maskable byte 0 returns {request, request AND enable}, with the request in bits 7:4. A read of maskable byte 1 returns {0, level[2:0], enable[3:0]}.
- R4: A write to maskable byte 0 uses data[7:4] as a mask M and data[3:0] as a value V, per bit: M=1,V=1 sets; M=0,V=1 clears; otherwise the bit is kept.
- R5: A write to maskable byte 1 loads the level from data[6:4] and the enable from data[3:0].
- R6: A read of non-maskable byte 0 returns the request in bits 3:0. A write to that byte clears each request bit whose data bit is 1.
- R7: A write to non-maskable byte 3 ORs data[3:0] into the request and raises no pulse.
- R8: After reset, every request and level is 0, every trigger mode is 3 (falling edge), non-maskable enables are 4'b1111 and maskable enables are 0.
- R9: Trigger byte 0 holds groups 23..26 and byte 1 holds groups 27..30. Each group has 2 bits, with the lowest group in bits 1:0. The codes are 0 active low, 1 active high, 2 rising, 3 falling. Other trigger offsets read 0 and ignore writes.
- R10: In an edge mode (code 2 or 3), any change of an input bit, rising or falling, sets its request bit in the cycle after the change.
- R11: In a level mode (code 0 or 1), an input bit at 1 sets its request bit every cycle. Hardware never clears a request, and a hardware set wins over a software clear in the same cycle.
- R12: nmi_pulse is high for one cycle after an input event in group 0 or 1 when that group's next request AND enable is nonzero.
- R13: pend[4g+3:4g] equals request AND enable of group g, and levels[3g+2:3g] equals its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 124 | Raw interrupt inputs, four per group |
| bus_we | input | 1 | Write strobe for the byte bus |
| bus_region | input | 1 | 0 selects the control region, 1 selects the trigger region |
| bus_addr | input | 8 | Byte offset within the selected region |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| pend | output | 124 | Request AND enable, four bits per group |
| levels | output | 93 | Priority level, three bits per group |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt pulse |

## Verification
The hardest case to reach is a hardware set landing in the same cycle as a software clear. The level-mode group is used for this: its input is held high while the clear byte is written, and the readback must still show the bit set. A second stimulus sequence is needed for the falling direction of an edge-mode group. The request is first set by a rising input and cleared by software, and the input is then dropped. The bit must be set again, which shows that the detector does not depend on direction. The software-set byte of a non-maskable group is checked against nmi_pulse, to show that software sets and hardware events are kept apart.

// File: rtl/irq_bank_pkg.sv
// Package: shared constants, trigger encoding and request update helper
// for the grouped interrupt register bank. The byte formats fix the
// per-group input count at 4 and the level width at 3.
package irq_bank_pkg;

    localparam int GRP_IN = 4;   // inputs per group (one nibble)
    localparam int LVL_W  = 3;   // level field width
    localparam int TRG_W  = 2;   // trigger code width

    typedef enum logic [TRG_W-1:0] {
        TRG_LOW  = 2'd0,
        TRG_HIGH = 2'd1,
        TRG_RISE = 2'd2,
        TRG_FALL = 2'd3
    } trig_e;

    // Mask/value update for a maskable request nibble.
    function automatic logic [GRP_IN-1:0] mask_update(
        input logic [GRP_IN-1:0] cur,
        input logic [GRP_IN-1:0] msk,
        input logic [GRP_IN-1:0] val
    );
        return (msk & (val | cur)) | (~msk & ~val & cur);
    endfunction

endpackage

// File: rtl/irq_input_stage.sv
// Module: irq_input_stage
// Registers the raw interrupt vector once and flags every bit whose live
// value differs from the registered copy. Assumes the inputs are already
// synchronous to clk.
module irq_input_stage #(
    parameter int WIDTH = 124
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] evt
);

    logic [WIDTH-1:0] raw_q;

    // Hold last cycle's input image.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw;
    end

    // A difference in either direction is an event.
    assign evt = raw ^ raw_q;

endmodule

// File: rtl/irq_group_cell.sv
// Module: irq_group_cell
// State of one interrupt group: request, enable, level and trigger mode.
// Applies the software write for this group, then ORs in the hardware
// set, so a hardware set wins over a software clear in the same cycle.
// Non-maskable cells keep their enables at all ones and their trigger at
// falling edge. Assumes that at most one write strobe is active per cycle.
module irq_group_cell
    import irq_bank_pkg::*;
#(
    parameter bit IS_NMI  = 1'b0,
    parameter bit TRIG_WR = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GRP_IN-1:0] evt,
    input  logic [GRP_IN-1:0] raw,
    input  logic              wr_req,
    input  logic              wr_cfg,
    input  logic              wr_set,
    input  logic              wr_trig,
    input  logic [7:0]        wdata,
    input  logic [TRG_W-1:0]  trig_wdata,
    output logic [GRP_IN-1:0] req_q,
    output logic [GRP_IN-1:0] en_q,
    output logic [LVL_W-1:0]  lvl_q,
    output logic [TRG_W-1:0]  trig_q,
    output logic [GRP_IN-1:0] req_nxt
);

    logic [GRP_IN-1:0] hw_set;
    logic [GRP_IN-1:0] sw_req;

    // Edge codes take events; level codes take the live input.
    assign hw_set = trig_q[1] ? evt : raw;

    // Software effect on the request nibble.
    always_comb begin
        sw_req = req_q;
        if (IS_NMI) begin
            if (wr_req)      sw_req = req_q & ~wdata[3:0];
            else if (wr_set) sw_req = req_q | wdata[3:0];
        end else if (wr_req) begin
            sw_req = mask_update(req_q, wdata[7:4], wdata[3:0]);
        end
    end

    assign req_nxt = sw_req | hw_set;

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_nxt;
    end

    // Enable and level registers (writable only in maskable cells).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= IS_NMI ? {GRP_IN{1'b1}} : {GRP_IN{1'b0}};
            lvl_q <= '0;
        end else if (!IS_NMI && wr_cfg) begin
            en_q  <= wdata[3:0];
            lvl_q <= wdata[6:4];
        end
    end

    // Trigger mode register (writable only in configurable cells).
    always_ff @(posedge clk) begin
        if (!rst_n)                trig_q <= TRG_FALL;
        else if (TRIG_WR && wr_trig) trig_q <= trig_wdata;
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q[1] && (evt != '0)) |=> ((req_q & $past(evt)) == $past(evt))); // R10
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_q[1] && (raw != '0)) |=> ((req_q & $past(raw)) == $past(raw))); // R11
    AST_NO_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req) |=> ((req_q & $past(req_q)) == $past(req_q))); // R11

endmodule

// File: rtl/irq_reg_decode.sv
// Module: irq_reg_decode
// Decodes the byte bus into per-group write strobes and builds the read
// data from the flattened group state. The read path is combinational.
// Assumes TRIG_FIRST + 4*TRIG_BYTES <= NUM_GROUPS.
module irq_reg_decode
    import irq_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NMI_GROUPS = 2,
    parameter int TRIG_FIRST = 23,
    parameter int TRIG_BYTES = 2,
    parameter int ADDR_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_we,
    input  logic                          bus_region,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [GRP_IN*NUM_GROUPS-1:0]  req_all,
    input  logic [GRP_IN*NUM_GROUPS-1:0]  en_all,
    input  logic [LVL_W*NUM_GROUPS-1:0]   lvl_all,
    input  logic [TRG_W*NUM_GROUPS-1:0]   trig_all,
    output logic [NUM_GROUPS-1:0]         wr_req,
    output logic [NUM_GROUPS-1:0]         wr_cfg,
    output logic [NUM_GROUPS-1:0]         wr_set,
    output logic [NUM_GROUPS-1:0]         wr_trig,
    output logic [7:0]                    bus_rdata
);

    localparam int CTL_BYTES = NUM_GROUPS * 4;
    localparam int TRG_LAST  = TRIG_FIRST + TRIG_BYTES * 4;
    localparam int PER_BYTE  = 8 / TRG_W;

    int         grp_i;
    int         addr_i;
    logic [1:0] sel;
    logic       ctl_hit;
    logic       trg_hit;

    assign addr_i  = int'(bus_addr);
    assign grp_i   = addr_i / 4;
    assign sel     = bus_addr[1:0];
    assign ctl_hit = !bus_region && (addr_i < CTL_BYTES);
    assign trg_hit = bus_region && (addr_i < TRIG_BYTES);

    // Per-group write strobes.
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            wr_req[g]  = bus_we && ctl_hit && (grp_i == g) && (sel == 2'd0);
            wr_cfg[g]  = bus_we && ctl_hit && (grp_i == g) && (sel == 2'd1) && (g >= NMI_GROUPS);
            wr_set[g]  = bus_we && ctl_hit && (grp_i == g) && (sel == 2'd3) && (g <  NMI_GROUPS);
            wr_trig[g] = bus_we && trg_hit && (g >= TRIG_FIRST) && (g < TRG_LAST)
                         && (addr_i == (g - TRIG_FIRST) / PER_BYTE);
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (ctl_hit) begin
            if (grp_i < NMI_GROUPS) begin
                if (sel == 2'd0) bus_rdata = {4'b0, req_all[grp_i*GRP_IN +: GRP_IN]};
            end else begin
                case (sel)
                    2'd0: bus_rdata = {req_all[grp_i*GRP_IN +: GRP_IN],
                                       req_all[grp_i*GRP_IN +: GRP_IN] & en_all[grp_i*GRP_IN +: GRP_IN]};
                    2'd1: bus_rdata = {1'b0, lvl_all[grp_i*LVL_W +: LVL_W],
                                       en_all[grp_i*GRP_IN +: GRP_IN]};
                    default: bus_rdata = '0;
                endcase
            end
        end else if (trg_hit) begin
            for (int k = 0; k < PER_BYTE; k++) begin
                bus_rdata[k*TRG_W +: TRG_W] =
                    trig_all[(TRIG_FIRST + addr_i*PER_BYTE + k)*TRG_W +: TRG_W];
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_req, wr_cfg, wr_set})); // R2
    AST_ONE_TRIG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(wr_trig) == 0) || ($countones(wr_trig) == PER_BYTE)); // R9

endmodule

// File: rtl/irq_group_bank.sv
// Module: irq_group_bank (top)
// Bank of interrupt group state: an input stage, one cell per group, the
// bus decoder and the non-maskable pulse register. Groups below NMI_GROUPS
// are non-maskable. Groups TRIG_FIRST .. TRIG_FIRST+4*TRIG_BYTES-1 have a
// writable trigger mode. Assumes irq_in is synchronous to clk.
module irq_group_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NMI_GROUPS = 2,
    parameter int TRIG_FIRST = 23,
    parameter int TRIG_BYTES = 2,
    parameter int ADDR_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [GRP_IN*NUM_GROUPS-1:0] irq_in,
    input  logic                         bus_we,
    input  logic                         bus_region,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [7:0]                   bus_wdata,
    output logic [7:0]                   bus_rdata,
    output logic [GRP_IN*NUM_GROUPS-1:0] pend,
    output logic [LVL_W*NUM_GROUPS-1:0]  levels,
    output logic                         nmi_pulse
);

    localparam int NIN      = GRP_IN * NUM_GROUPS;
    localparam int TRG_LAST = TRIG_FIRST + TRIG_BYTES * 4;
    localparam int PER_BYTE = 8 / TRG_W;

    logic [NIN-1:0]              evt;
    logic [NIN-1:0]              req_all;
    logic [NIN-1:0]              en_all;
    logic [NIN-1:0]              nxt_all;
    logic [LVL_W*NUM_GROUPS-1:0] lvl_all;
    logic [TRG_W*NUM_GROUPS-1:0] trig_all;
    logic [NUM_GROUPS-1:0]       wr_req, wr_cfg, wr_set, wr_trig;
    logic [NUM_GROUPS-1:0]       nmi_hit;

    irq_input_stage #(.WIDTH(NIN)) u_in (
        .clk (clk),
        .rst_n (rst_n),
        .raw (irq_in),
        .evt (evt)
    );

    irq_reg_decode #(
        .NUM_GROUPS (NUM_GROUPS),
        .NMI_GROUPS (NMI_GROUPS),
        .TRIG_FIRST (TRIG_FIRST),
        .TRIG_BYTES (TRIG_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_region (bus_region),
        .bus_addr   (bus_addr),
        .req_all    (req_all),
        .en_all     (en_all),
        .lvl_all    (lvl_all),
        .trig_all   (trig_all),
        .wr_req     (wr_req),
        .wr_cfg     (wr_cfg),
        .wr_set     (wr_set),
        .wr_trig    (wr_trig),
        .bus_rdata  (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam bit NMI_G = (g < NMI_GROUPS);
        localparam bit TRG_G = (g >= TRIG_FIRST) && (g < TRG_LAST);
        logic [TRG_W-1:0] twd;

        if (TRG_G) begin : g_twd
            localparam int FLD = (g - TRIG_FIRST) % PER_BYTE;
            assign twd = bus_wdata[FLD*TRG_W +: TRG_W];
        end else begin : g_notwd
            assign twd = '0;
        end

        irq_group_cell #(.IS_NMI(NMI_G), .TRIG_WR(TRG_G)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt        (evt[g*GRP_IN +: GRP_IN]),
            .raw        (irq_in[g*GRP_IN +: GRP_IN]),
            .wr_req     (wr_req[g]),
            .wr_cfg     (wr_cfg[g]),
            .wr_set     (wr_set[g]),
            .wr_trig    (wr_trig[g]),
            .wdata      (bus_wdata),
            .trig_wdata (twd),
            .req_q      (req_all[g*GRP_IN +: GRP_IN]),
            .en_q       (en_all[g*GRP_IN +: GRP_IN]),
            .lvl_q      (lvl_all[g*LVL_W +: LVL_W]),
            .trig_q     (trig_all[g*TRG_W +: TRG_W]),
            .req_nxt    (nxt_all[g*GRP_IN +: GRP_IN])
        );

        // Event in a non-maskable group with an enabled next request.
        if (NMI_G) begin : g_nmi
            assign nmi_hit[g] = (evt[g*GRP_IN +: GRP_IN] != '0) &&
                                ((nxt_all[g*GRP_IN +: GRP_IN] & en_all[g*GRP_IN +: GRP_IN]) != '0);
        end else begin : g_nonmi
            assign nmi_hit[g] = 1'b0;
        end
    end

    // Register the non-maskable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pulse <= 1'b0;
        else        nmi_pulse <= |nmi_hit;
    end

    assign pend   = req_all & en_all;
    assign levels = lvl_all;

    AST_NMI_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> ($past(evt[NMI_GROUPS*GRP_IN-1:0]) != '0)); // R12
    AST_NMI_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> (pend[NMI_GROUPS*GRP_IN-1:0] != '0)); // R12

endmodule

// File: tb/tb_irq_group_bank.sv
module tb_irq_group_bank;

    localparam int NG  = 31;
    localparam int NIN = NG * 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NIN-1:0] irq_in = '0;
    logic           bus_we = 1'b0;
    logic           bus_region = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic [NIN-1:0] pend;
    logic [NG*3-1:0] levels;
    logic           nmi_pulse;

    int checks = 0;
    int errors = 0;

    irq_group_bank dut (
        .clk (clk), .rst_n (rst_n), .irq_in (irq_in),
        .bus_we (bus_we), .bus_region (bus_region), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pend (pend), .levels (levels), .nmi_pulse (nmi_pulse)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic region, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_region = region; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic region, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_region = region; bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic drive_in(input int idx, input logic v);
        @(negedge clk);
        irq_in[idx] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R8 pend zero", 32'(pend == '0), 1);
        chk("R8 levels zero", 32'(levels == '0), 1);
        chk("R8 nmi low", 32'(nmi_pulse), 0);
        rd(1'b1, 8'd0, d); chk("R8 trig byte0", 32'(d), 32'hFF);
        rd(1'b1, 8'd1, d); chk("R8 trig byte1", 32'(d), 32'hFF);
        rd(1'b0, 8'd21, d); chk("R8 maskable cfg", 32'(d), 32'h00);
        rd(1'b0, 8'd0, d); chk("R8 nmi req", 32'(d), 32'h00);
    endtask

    task automatic t_maskable();
        logic [7:0] d;
        logic [NIN-1:0] exp;
        wr(1'b0, 8'd21, 8'h5F);
        rd(1'b0, 8'd21, d); chk("R5 cfg readback", 32'(d), 32'h5F);
        chk("R13 level g5", 32'(levels[15 +: 3]), 5);
        drive_in(22, 1'b1);
        exp = '0; exp[22] = 1'b1;
        chk("R1 input 22 maps to g5 bit2", 32'(pend == exp), 1);
        rd(1'b0, 8'd20, d); chk("R3 g5 byte0", 32'(d), 32'h44);
        wr(1'b0, 8'd20, 8'h11);
        rd(1'b0, 8'd20, d); chk("R4 set bit0", 32'(d), 32'h55);
        wr(1'b0, 8'd20, 8'h36);
        rd(1'b0, 8'd20, d); chk("R4 mixed mask/value", 32'(d), 32'h33);
        wr(1'b0, 8'd21, 8'h51);
        rd(1'b0, 8'd20, d); chk("R3 masked byte0", 32'(d), 32'h31);
        chk("R13 pend g5", 32'(pend[20 +: 4]), 32'h1);
        wr(1'b0, 8'd20, 8'h0F);
        rd(1'b0, 8'd20, d); chk("R4 clear all", 32'(d), 32'h00);
    endtask

    task automatic t_nmi();
        logic [7:0] d;
        drive_in(1, 1'b1);
        chk("R12 pulse on g0 event", 32'(nmi_pulse), 1);
        chk("R8 nmi enable visible", 32'(pend[3:0]), 32'h2);
        @(negedge clk);
        chk("R12 pulse one cycle", 32'(nmi_pulse), 0);
        rd(1'b0, 8'd0, d); chk("R6 nmi read", 32'(d), 32'h02);
        wr(1'b0, 8'd0, 8'h02);
        rd(1'b0, 8'd0, d); chk("R6 write one clears", 32'(d), 32'h00);
        wr(1'b0, 8'd3, 8'h09);
        chk("R7 no pulse on sw set", 32'(nmi_pulse), 0);
        rd(1'b0, 8'd0, d); chk("R7 sw set", 32'(d), 32'h09);
        wr(1'b0, 8'd0, 8'h0F);
        drive_in(4, 1'b1);
        chk("R12 pulse on g1 event", 32'(nmi_pulse), 1);
        rd(1'b0, 8'd4, d); chk("R1 input 4 maps to g1", 32'(d), 32'h01);
        wr(1'b0, 8'd4, 8'h0F);
    endtask

    task automatic t_trigger();
        logic [7:0] d;
        wr(1'b1, 8'd1, 8'h4B);
        rd(1'b1, 8'd1, d); chk("R9 trig byte1", 32'(d), 32'h4B);
        rd(1'b1, 8'd0, d); chk("R9 trig byte0 kept", 32'(d), 32'hFF);
        wr(1'b1, 8'd2, 8'h00);
        rd(1'b1, 8'd2, d); chk("R9 trig offset2 zero", 32'(d), 32'h00);
        rd(1'b1, 8'd0, d); chk("R9 offset2 write ignored", 32'(d), 32'hFF);
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(1'b0, 8'd117, 8'h0F);
        drive_in(117, 1'b1);
        rd(1'b0, 8'd116, d); chk("R11 level sets", 32'(d), 32'h22);
        drive_in(117, 1'b0);
        @(negedge clk); @(negedge clk);
        rd(1'b0, 8'd116, d); chk("R11 no auto clear", 32'(d), 32'h22);
        wr(1'b0, 8'd116, 8'h0F);
        rd(1'b0, 8'd116, d); chk("R11 cleared when low", 32'(d), 32'h00);
        drive_in(117, 1'b1);
        wr(1'b0, 8'd116, 8'h0F);
        rd(1'b0, 8'd116, d); chk("R11 hw set wins clear", 32'(d), 32'h22);
        drive_in(117, 1'b0);
        wr(1'b0, 8'd116, 8'h0F);
        rd(1'b0, 8'd116, d); chk("R11 final clear", 32'(d), 32'h00);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        wr(1'b0, 8'd113, 8'h7F);
        chk("R13 level g28", 32'(levels[84 +: 3]), 7);
        drive_in(112, 1'b1);
        chk("R10 rise sets", 32'(pend[112 +: 4]), 32'h1);
        wr(1'b0, 8'd112, 8'h0F);
        chk("R10 cleared", 32'(pend[112 +: 4]), 32'h0);
        drive_in(112, 1'b0);
        chk("R10 fall also sets", 32'(pend[112 +: 4]), 32'h1);
        wr(1'b0, 8'd112, 8'h0F);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(1'b0, 8'd124, 8'hFF);
        rd(1'b0, 8'd124, d); chk("R2 offset 124 reads 0", 32'(d), 32'h00);
        wr(1'b0, 8'd23, 8'hFF);
        rd(1'b0, 8'd20, d); chk("R2 g5 byte3 ignored", 32'(d), 32'h00);
        rd(1'b0, 8'd21, d); chk("R2 g5 cfg kept", 32'(d), 32'h51);
        rd(1'b0, 8'd22, d); chk("R2 g5 byte2 reads 0", 32'(d), 32'h00);
        wr(1'b0, 8'd6, 8'hFF);
        rd(1'b0, 8'd4, d); chk("R2 nmi byte2 ignored", 32'(d), 32'h00);
        chk("R2 pend untouched", 32'(pend == '0), 1);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_maskable();
        t_nmi();
        t_trigger();
        t_level();
        t_edge();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule